// File: doc/BRIEF.md
# Fractional Sample Clock Generator Bank

This block derives sample-rate strobes from a small set of master tick sources. It uses an error accumulator of the Bresenham kind. Each generator channel holds three settings: a source selector, an increment and a modulus-control word. The modulus-control word is the modulus minus one, truncated to the field width. On every tick of the selected source the channel adds the increment to its accumulator. Whenever the sum passes the modulus-control value, the channel folds the sum back by one modulus and raises its strobe for one clock. Over time the strobe rate equals the source rate times increment over modulus.

Three kinds of tick source exist, and each arrives as a one-clock enable:

- a master tick for the 48 kHz family;
- a master tick for the 44.1 kHz family;
- a tick recovered from a digital audio receiver.

The bank holds several identical channels, three by default. Consumers refer to them as generators 1, 2 and 3, which are strobe bits 0, 1 and 2. One shared configuration bus programs the channels, and a per-channel write enable picks which ones take the values.

Top module: `frg_bank`

## Requirements
- R1: After reset every channel has its source set to none (code 3), its increment at 0 and its accumulator at 0. Its strobe stays low even when all sources tick.
- R2: Source code 0 selects the 48 kHz family tick, code 1 the 44.1 kHz family tick and code 2 the receiver tick. Ticks of the unselected sources have no effect on a channel.
- R3: Source code 3 selects no source, and the channel never strobes.
- R4: An increment of 0 never produces a strobe.
- R5: Start from a cleared accumulator and apply N ticks of the selected source. The number of strobes then equals floor(N * increment / (modulus_control + 1)), for any increment from 0 to modulus_control + 1.
- R6: A strobe is high for exactly one clock, in the cycle after the clock edge that sampled the causing tick.
- R7: A configuration write clears the channel's accumulator at the same clock edge that loads the new values. Any phase built up before the write is lost.
- R8: A write reaches only the channels whose write-enable bit is set. The others keep their settings and their accumulated phase.
- R9: Modulus-control 0xFFFF means a modulus of 65536. For example, increment 0x8000 strobes on every second tick.
- R10: A tick that arrives in the same cycle as a configuration write to that channel is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_f48_i | input | 1 | One-clock tick of the 48 kHz family master (source code 0) |
| tick_f44_i | input | 1 | One-clock tick of the 44.1 kHz family master (source code 1) |
| tick_rx_i | input | 1 | One-clock tick recovered from the digital receiver (source code 2) |
| cfg_we_i | input | 3 | Per-channel write enable; bit k loads channel k |
| cfg_src_i | input | 2 | Source code to load |
| cfg_inc_i | input | 16 | Increment to load |
| cfg_modctl_i | input | 16 | Modulus minus one to load |
| strobe_o | output | 3 | Per-channel rate strobe |

## Verification
The accumulator assertions assume that a programmed increment never exceeds the modulus (modulus_control + 1). Under that condition one tick can cause at most one fold, so the accumulator stays below the modulus. This input condition is itself checked as a property on each channel. The sweep programs only increments from 0 up to exactly the modulus for every small modulus. The large-modulus cases use increments far below 65536. Ticks are never applied to a channel in the cycle of its own write, except in the one directed case that checks that such a tick is dropped.

// File: rtl/frg_pkg.sv
package frg_pkg;

  // number of tick sources feeding each channel
  localparam int FRG_NUM_SRC = 3;
  localparam int FRG_SRC_W   = 2;

  typedef enum logic [FRG_SRC_W-1:0] {
    FRG_SRC_F48  = 2'd0,
    FRG_SRC_F44  = 2'd1,
    FRG_SRC_RX   = 2'd2,
    FRG_SRC_NONE = 2'd3
  } frg_src_e;

endpackage

// File: rtl/frg_src_mux.sv
module frg_src_mux
  import frg_pkg::*;
#(
  parameter int NUM_SRC = FRG_NUM_SRC,
  parameter int SRC_W   = FRG_SRC_W
) (
  input  logic [SRC_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] ticks_i,
  output logic               tick_o
);

  // codes at or above NUM_SRC match nothing, so the channel sees no tick
  always_comb begin
    tick_o = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_i == SRC_W'(k)) tick_o = ticks_i[k];
    end
  end

endmodule

// File: rtl/frg_cfg_reg.sv
module frg_cfg_reg
  import frg_pkg::*;
#(
  parameter int ACC_W = 16,
  parameter int SRC_W = FRG_SRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [SRC_W-1:0] src_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] modctl_i,
  output logic [SRC_W-1:0] src_o,
  output logic [ACC_W-1:0] inc_o,
  output logic [ACC_W-1:0] modctl_o,
  output logic             load_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_o    <= SRC_W'(FRG_SRC_NONE);
      inc_o    <= '0;
      modctl_o <= '0;
    end else if (we_i) begin
      src_o    <= src_i;
      inc_o    <= inc_i;
      modctl_o <= modctl_i;
    end
  end

  // the accumulator clears at the same edge that loads the new settings
  assign load_o = we_i;

endmodule

// File: rtl/frg_accum.sv
module frg_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [ACC_W-1:0] inc_i,
  input  logic [ACC_W-1:0] modctl_i,
  output logic             strobe_o,
  output logic [ACC_W-1:0] acc_o
);

  localparam int SUM_W = ACC_W + 1;
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  function automatic logic [SUM_W-1:0] f_sum(input logic [ACC_W-1:0] a,
                                             input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic f_wraps(input logic [SUM_W-1:0] s,
                                   input logic [ACC_W-1:0] mc);
    return s > {1'b0, mc};
  endfunction

  function automatic logic [ACC_W-1:0] f_fold(input logic [SUM_W-1:0] s,
                                              input logic [ACC_W-1:0] mc);
    logic [SUM_W-1:0] diff;
    diff = s - ({1'b0, mc} + ONE);
    return diff[ACC_W-1:0];
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic             strobe_q;
  logic [SUM_W-1:0] sum_w;
  logic             wrap_w;
  logic             step_w;

  assign sum_w  = f_sum(acc_q, inc_i);
  assign wrap_w = f_wraps(sum_w, modctl_i);
  assign step_w = tick_i && !load_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (load_i) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else if (step_w) begin
      acc_q    <= wrap_w ? f_fold(sum_w, modctl_i) : sum_w[ACC_W-1:0];
      strobe_q <= wrap_w;
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign strobe_o = strobe_q;
  assign acc_o    = acc_q;

  // accumulated phase always stays below the modulus
  p_acc_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= modctl_i);

  // input condition: the increment never exceeds the modulus
  p_inc_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, inc_i} <= ({1'b0, modctl_i} + ONE));

  // a write leaves a cleared accumulator and a quiet strobe
  p_clear_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0) && !strobe_q);

  // a strobe needs an accepted tick with a non-zero increment one cycle earlier
  p_strobe_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> $past(tick_i) && !$past(load_i) && ($past(inc_i) != '0));

endmodule

// File: rtl/frg_channel.sv
module frg_channel
  import frg_pkg::*;
#(
  parameter int ACC_W   = 16,
  parameter int SRC_W   = FRG_SRC_W,
  parameter int NUM_SRC = FRG_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] ticks_i,
  input  logic               we_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [ACC_W-1:0]   inc_i,
  input  logic [ACC_W-1:0]   modctl_i,
  output logic               strobe_o
);

  logic [SRC_W-1:0] src_q;
  logic [ACC_W-1:0] inc_q;
  logic [ACC_W-1:0] modctl_q;
  logic             load_w;
  logic             tick_sel_w;
  logic [ACC_W-1:0] acc_w;

  frg_cfg_reg #(.ACC_W(ACC_W), .SRC_W(SRC_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (we_i),
    .src_i    (src_i),
    .inc_i    (inc_i),
    .modctl_i (modctl_i),
    .src_o    (src_q),
    .inc_o    (inc_q),
    .modctl_o (modctl_q),
    .load_o   (load_w)
  );

  frg_src_mux #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) mux_i (
    .sel_i   (src_q),
    .ticks_i (ticks_i),
    .tick_o  (tick_sel_w)
  );

  frg_accum #(.ACC_W(ACC_W)) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_sel_w),
    .load_i   (load_w),
    .inc_i    (inc_q),
    .modctl_i (modctl_q),
    .strobe_o (strobe_o),
    .acc_o    (acc_w)
  );

  // with no source selected the channel stays silent
  p_none_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_W'(FRG_SRC_NONE)) && $stable(src_q) |-> !strobe_o);

endmodule

// File: rtl/frg_bank.sv
module frg_bank
  import frg_pkg::*;
#(
  parameter int NUM_GEN = 3,
  parameter int ACC_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_f48_i,
  input  logic               tick_f44_i,
  input  logic               tick_rx_i,
  input  logic [NUM_GEN-1:0] cfg_we_i,
  input  logic [1:0]         cfg_src_i,
  input  logic [ACC_W-1:0]   cfg_inc_i,
  input  logic [ACC_W-1:0]   cfg_modctl_i,
  output logic [NUM_GEN-1:0] strobe_o
);

  logic [FRG_NUM_SRC-1:0] ticks_w;

  // bit position equals source code
  assign ticks_w = {tick_rx_i, tick_f44_i, tick_f48_i};

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
    frg_channel #(
      .ACC_W   (ACC_W),
      .SRC_W   (FRG_SRC_W),
      .NUM_SRC (FRG_NUM_SRC)
    ) chan_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ticks_i  (ticks_w),
      .we_i     (cfg_we_i[g]),
      .src_i    (cfg_src_i),
      .inc_i    (cfg_inc_i),
      .modctl_i (cfg_modctl_i),
      .strobe_o (strobe_o[g])
    );
  end

endmodule

// File: tb/frg_bank_tb.sv
`timescale 1ns/1ps
module frg_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_f48_i = 1'b0;
  logic        tick_f44_i = 1'b0;
  logic        tick_rx_i = 1'b0;
  logic [2:0]  cfg_we_i = '0;
  logic [1:0]  cfg_src_i = '0;
  logic [15:0] cfg_inc_i = '0;
  logic [15:0] cfg_modctl_i = '0;
  logic [2:0]  strobe_o;

  int checks = 0;
  int failures = 0;
  int cnt [3] = '{0, 0, 0};

  always #2 clk = ~clk;

  frg_bank dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_f48_i   (tick_f48_i),
    .tick_f44_i   (tick_f44_i),
    .tick_rx_i    (tick_rx_i),
    .cfg_we_i     (cfg_we_i),
    .cfg_src_i    (cfg_src_i),
    .cfg_inc_i    (cfg_inc_i),
    .cfg_modctl_i (cfg_modctl_i),
    .strobe_o     (strobe_o)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) if (strobe_o[i]) cnt[i] <= cnt[i] + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_ticks(input int which, input logic v);
    case (which)
      0: tick_f48_i = v;
      1: tick_f44_i = v;
      default: tick_rx_i = v;
    endcase
  endtask

  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); set_ticks(which, 1'b1);
      @(negedge clk); set_ticks(which, 1'b0);
    end
  endtask

  task automatic write_cfg(input logic [2:0] we, input logic [1:0] src,
                           input int inc, input int mc);
    @(negedge clk);
    cfg_we_i = we; cfg_src_i = src;
    cfg_inc_i = 16'(inc); cfg_modctl_i = 16'(mc);
    @(negedge clk);
    cfg_we_i = '0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  function automatic int expect_cnt(input int n, input int inc, input int mc);
    longint num;
    num = longint'(n) * longint'(inc);
    return int'(num / (longint'(mc) + 1));
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int b [3];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, all sources tick, nothing comes out
    chk("R1 strobe after reset", int'(strobe_o), 0);
    b = cnt;
    pulse(0, 3); pulse(1, 3); pulse(2, 3);
    settle();
    for (int i = 0; i < 3; i++) chk("R1 no strobes from reset config", cnt[i] - b[i], 0);

    // R2 R4 R5: sweep small moduli, every legal increment, each channel on its own source
    for (int mc = 0; mc < 6; mc++) begin
      for (int inc = 0; inc <= mc + 1; inc++) begin
        for (int c = 0; c < 3; c++) write_cfg(3'(1 << c), 2'(c), inc, mc);
        for (int s = 0; s < 3; s++) begin
          b = cnt;
          pulse(s, 13);
          settle();
          for (int c = 0; c < 3; c++) begin
            if (c == s)
              chk(inc == 0 ? "R4 zero increment" : "R5 strobe count",
                  cnt[c] - b[c], expect_cnt(13, inc, mc));
            else
              chk("R2 unselected source ignored", cnt[c] - b[c], 0);
          end
        end
      end
    end

    // R3: no-source code
    write_cfg(3'b111, 2'd3, 1, 0);
    b = cnt;
    pulse(0, 4); pulse(1, 4); pulse(2, 4);
    settle();
    for (int i = 0; i < 3; i++) chk("R3 source none silent", cnt[i] - b[i], 0);

    // R9: full-width modulus
    write_cfg(3'b001, 2'd0, 16'h8000, 16'hFFFF);
    write_cfg(3'b010, 2'd0, 1, 16'hFFFF);
    write_cfg(3'b100, 2'd0, 300, 999);
    b = cnt;
    pulse(0, 10);
    settle();
    chk("R9 modulus 65536 half rate", cnt[0] - b[0], 5);
    chk("R9 modulus 65536 tiny increment", cnt[1] - b[1], 0);
    chk("R5 larger modulus", cnt[2] - b[2], expect_cnt(10, 300, 999));

    // R7: rewrite drops accumulated phase (3 of 4, then 3 more would strobe)
    write_cfg(3'b001, 2'd0, 3, 3);
    b = cnt;
    pulse(0, 1);
    write_cfg(3'b001, 2'd0, 3, 3);
    pulse(0, 1);
    settle();
    chk("R7 write clears phase", cnt[0] - b[0], 0);

    // R8: writing channel 1 leaves channel 0 phase intact
    write_cfg(3'b001, 2'd0, 1, 1);
    write_cfg(3'b010, 2'd1, 1, 0);
    b = cnt;
    pulse(0, 1);
    write_cfg(3'b010, 2'd2, 1, 0);
    pulse(0, 1);
    settle();
    chk("R8 other channel keeps phase", cnt[0] - b[0], 1);
    chk("R8 rewritten channel quiet on f48", cnt[1] - b[1], 0);

    // R10: tick in the write cycle is dropped
    write_cfg(3'b001, 2'd0, 1, 0);
    b = cnt;
    @(negedge clk);
    cfg_we_i = 3'b001; cfg_src_i = 2'd0; cfg_inc_i = 16'd1; cfg_modctl_i = 16'd0;
    tick_f48_i = 1'b1;
    @(negedge clk);
    cfg_we_i = '0; tick_f48_i = 1'b0;
    settle();
    chk("R10 tick during write dropped", cnt[0] - b[0], 0);

    // R6: strobe timing and width
    @(negedge clk); tick_f48_i = 1'b1;
    @(negedge clk); tick_f48_i = 1'b0;
    chk("R6 strobe cycle after tick", int'(strobe_o[0]), 1);
    @(negedge clk);
    chk("R6 strobe one clock wide", int'(strobe_o[0]), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule